// File: doc/BRIEF.md
# Bus-Cycle Break Condition Comparator

This debug block watches a processor bus and requests a break whenever a bus cycle meets a programmed condition. It has two independent channels. Each channel has a break address, a cycle-kind selector (fetch only, data only, either, or off) and an operand-size selector (byte, word, longword, or any size). The second channel also has a data value and a data mask. When data matching is switched on there, a data cycle must meet both the address condition and the data condition.

The address compare narrows as the access gets wider. A longword access ignores the two lowest address bits, a word access ignores bit 0, and a byte access compares every bit. As a result, one programmed address can catch a longword, a word and a byte access to the same longword. Data is compared on the byte lane or halfword lane that the access occupies under a big-endian layout.

The compare is pure combinational logic on the bus inputs. Its result is registered, so each channel raises a one-cycle break pulse on the clock after the matching cycle.

Top module: `cycle_break_match`

## Requirements
- R1: For a longword access (size code 2), only address bits 31:2 of the channel address are compared with the bus address; bits 1:0 are don't-care.
- R2: For a word access (size code 1), address bits 31:1 are compared. For a byte access (size code 0), all 32 bits are compared. Size code 3 on the bus never matches.
- R3: With a channel address of 0x00001003, all three of these meet the address condition: a longword access at 0x00001000, a word access at 0x00001002 and a byte access at 0x00001003.
- R4: Cycle-kind selector, where bit 0 enables fetch cycles (busFetch=1) and bit 1 enables data cycles (busFetch=0). Code 01 is fetch only, 10 is data only, 11 is either, and 00 never fires.
- R5: The operand-size selector uses the bus size codes (0 byte, 1 word, 2 longword). A channel fires only on accesses of the selected size. Code 3 means any size, and the compare width then follows the actual access.
- R6: With ch1DataEn=1 on a data cycle, channel 1 fires only when both the address and the data conditions hold. A mask bit of 1 excludes that data bit from the compare; a mask bit of 0 requires an exact match.
- R7: For word and byte accesses, bits 31:16 of ch1Data and ch1Mask are ignored. A word is taken from bus data bits 31:16 when address bit 1 is 0, and from bits 15:0 when it is 1.
- R8: A byte access takes the bus byte lane chosen by address bits 1:0 under a big-endian layout: 0 selects bits 31:24 and 3 selects bits 7:0. That byte is compared with bits 7:0 of ch1Data and ch1Mask.
- R9: On a fetch cycle the data condition never applies, even when ch1DataEn=1.
- R10: brkPulse[c] is high for the single clock after a cycle with busValid=1 that matches channel c, and low otherwise. A synchronous reset clears both pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busValid | input | 1 | A bus cycle is present this clock |
| busFetch | input | 1 | 1 = instruction fetch, 0 = data access |
| busSize | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| busAddr | input | 32 | Bus address |
| busData | input | 32 | Bus data |
| ch0Addr | input | 32 | Channel 0 break address |
| ch0Kind | input | 2 | Channel 0 cycle-kind selector |
| ch0Size | input | 2 | Channel 0 size selector (3 = any) |
| ch1Addr | input | 32 | Channel 1 break address |
| ch1Kind | input | 2 | Channel 1 cycle-kind selector |
| ch1Size | input | 2 | Channel 1 size selector (3 = any) |
| ch1DataEn | input | 1 | Enable the data condition on channel 1 |
| ch1Data | input | 32 | Channel 1 data value |
| ch1Mask | input | 32 | Channel 1 data mask (1 = don't care) |
| brkPulse | output | 2 | Registered break pulse per channel |

## Verification
The hardest case to reach is a data hit on a narrow lane. It needs the right address, a size that agrees with the selector, an unmasked lane value equal to the low data bits, and junk in the ignored upper halves all at once. Uniform random stimulus would almost never line these up. The directed stimulus builds such cycles explicitly: it walks all four byte lanes and both word lanes with deliberately conflicting upper bits. The random phase confines addresses to a few bytes around the break address and often drives the programmed data value onto the bus, so that hits and near misses both occur often.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int NUM_CH = 2;
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_ANY  = 2'd3
  } sizeCode_e;

  typedef struct packed {
    logic [NUM_CH-1:0] arm;
    logic              dataCheck;
    logic              isLong;
    logic              isWord;
    logic              isByte;
  } ctlStrobe_t;
endpackage

// File: rtl/cbm_ctrl.sv
module cbm_ctrl
  import cbm_pkg::*;
(
  input  logic                   busValid,
  input  logic                   busFetch,
  input  logic [1:0]             busSize,
  input  logic [NUM_CH-1:0][1:0] kindSel,
  input  logic [NUM_CH-1:0][1:0] sizeSel,
  input  logic                   dataEn,
  output ctlStrobe_t             strobe
);
  logic sizeLegal;
  logic [NUM_CH-1:0] kindOk;
  logic [NUM_CH-1:0] sizeOk;

  assign sizeLegal = (busSize != SZ_ANY);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign kindOk[c] = busFetch ? kindSel[c][0] : kindSel[c][1];
    assign sizeOk[c] = (sizeSel[c] == SZ_ANY) || (sizeSel[c] == busSize);
  end

  always_comb begin
    strobe.isLong    = (busSize == SZ_LONG);
    strobe.isWord    = (busSize == SZ_WORD);
    strobe.isByte    = (busSize == SZ_BYTE);
    strobe.dataCheck = dataEn & ~busFetch;
    strobe.arm       = kindOk & sizeOk & {NUM_CH{busValid & sizeLegal}};
  end
endmodule

// File: rtl/cbm_datapath.sv
module cbm_datapath
  import cbm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  ctlStrobe_t                    strobe,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busData,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] chAddr,
  input  logic [DATA_W-1:0]             cmpData,
  input  logic [DATA_W-1:0]             cmpMask,
  output logic [NUM_CH-1:0]             brkPulse
);
  logic [ADDR_W-1:0] careMask;
  logic [NUM_CH-1:0] addrHit;
  logic [NUM_CH-1:0] fire;
  logic [BYTE_W-1:0] byteLane;
  logic [HALF_W-1:0] wordLane;
  logic              dataHit;

  // low address bits drop out of the compare as the access widens
  assign careMask = {{(ADDR_W-2){1'b1}}, ~strobe.isLong, strobe.isByte};

  always_comb begin
    case (busAddr[1:0])
      2'd0:    byteLane = busData[31:24];
      2'd1:    byteLane = busData[23:16];
      2'd2:    byteLane = busData[15:8];
      default: byteLane = busData[7:0];
    endcase
    wordLane = busAddr[1] ? busData[HALF_W-1:0] : busData[DATA_W-1:HALF_W];
  end

  always_comb begin
    if (strobe.isLong)
      dataHit = ((busData ^ cmpData) & ~cmpMask) == '0;
    else if (strobe.isWord)
      dataHit = ((wordLane ^ cmpData[HALF_W-1:0]) & ~cmpMask[HALF_W-1:0]) == '0;
    else if (strobe.isByte)
      dataHit = ((byteLane ^ cmpData[BYTE_W-1:0]) & ~cmpMask[BYTE_W-1:0]) == '0;
    else
      dataHit = 1'b0;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    assign addrHit[c] = ((busAddr ^ chAddr[c]) & careMask) == '0;
    if (c == NUM_CH - 1) begin : g_dataChan
      assign fire[c] = strobe.arm[c] & addrHit[c] & (~strobe.dataCheck | dataHit);
    end else begin : g_addrChan
      assign fire[c] = strobe.arm[c] & addrHit[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) brkPulse <= '0;
    else     brkPulse <= fire;
  end
endmodule

// File: rtl/cycle_break_match.sv
module cycle_break_match
  import cbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busFetch,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic [ADDR_W-1:0] ch0Addr,
  input  logic [1:0]        ch0Kind,
  input  logic [1:0]        ch0Size,
  input  logic [ADDR_W-1:0] ch1Addr,
  input  logic [1:0]        ch1Kind,
  input  logic [1:0]        ch1Size,
  input  logic              ch1DataEn,
  input  logic [DATA_W-1:0] ch1Data,
  input  logic [DATA_W-1:0] ch1Mask,
  output logic [NUM_CH-1:0] brkPulse
);
  ctlStrobe_t strobe;

  cbm_ctrl u_ctrl (
    .busValid (busValid),
    .busFetch (busFetch),
    .busSize  (busSize),
    .kindSel  ({ch1Kind, ch0Kind}),
    .sizeSel  ({ch1Size, ch0Size}),
    .dataEn   (ch1DataEn),
    .strobe   (strobe)
  );

  cbm_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .busAddr  (busAddr),
    .busData  (busData),
    .chAddr   ({ch1Addr, ch0Addr}),
    .cmpData  (ch1Data),
    .cmpMask  (ch1Mask),
    .brkPulse (brkPulse)
  );
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker (
  input logic        clk,
  input logic        rst,
  input logic        busValid,
  input logic        busFetch,
  input logic [1:0]  busSize,
  input logic [31:0] busAddr,
  input logic [31:0] busData,
  input logic [31:0] ch0Addr,
  input logic [1:0]  ch0Kind,
  input logic [1:0]  ch0Size,
  input logic [31:0] ch1Data,
  input logic [31:0] ch1Mask,
  input logic        ch1DataEn,
  input logic [1:0]  brkPulse
);
  AST_PULSE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (brkPulse != 2'b00) |-> $past(busValid)); // R10

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (brkPulse == 2'b00)); // R10

  AST_KIND_FILTER: assert property (@(posedge clk) disable iff (rst)
    brkPulse[0] |-> ($past(busFetch) ? $past(ch0Kind[0]) : $past(ch0Kind[1]))); // R4

  AST_LONG_ADDR: assert property (@(posedge clk) disable iff (rst)
    (brkPulse[0] && $past(busSize) == 2'd2) |-> ($past(busAddr[31:2]) == $past(ch0Addr[31:2]))); // R1

  AST_BYTE_ADDR: assert property (@(posedge clk) disable iff (rst)
    (brkPulse[0] && $past(busSize) == 2'd0) |-> ($past(busAddr) == $past(ch0Addr))); // R2

  AST_SIZE_FILTER: assert property (@(posedge clk) disable iff (rst)
    brkPulse[0] |-> ($past(ch0Size) == 2'd3 || $past(ch0Size) == $past(busSize))); // R5

  AST_LONG_DATA: assert property (@(posedge clk) disable iff (rst)
    (brkPulse[1] && $past(ch1DataEn) && !$past(busFetch) && $past(busSize) == 2'd2)
      |-> ((($past(busData) ^ $past(ch1Data)) & ~$past(ch1Mask)) == 32'h0)); // R6
endmodule

bind cycle_break_match cbm_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .busValid  (busValid),
  .busFetch  (busFetch),
  .busSize   (busSize),
  .busAddr   (busAddr),
  .busData   (busData),
  .ch0Addr   (ch0Addr),
  .ch0Kind   (ch0Kind),
  .ch0Size   (ch0Size),
  .ch1Data   (ch1Data),
  .ch1Mask   (ch1Mask),
  .ch1DataEn (ch1DataEn),
  .brkPulse  (brkPulse)
);

// File: tb/sim_cycle_break_match.sv
`timescale 1ns/1ps
module sim_cycle_break_match;
  logic        clk = 1'b0;
  logic        rst;
  logic        busValid, busFetch;
  logic [1:0]  busSize;
  logic [31:0] busAddr, busData;
  logic [31:0] ch0Addr, ch1Addr, ch1Data, ch1Mask;
  logic [1:0]  ch0Kind, ch0Size, ch1Kind, ch1Size;
  logic        ch1DataEn;
  logic [1:0]  brkPulse;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 0;

  always #2 clk = ~clk;

  cycle_break_match u0 (.*);

  // behavioural model of one channel's match for the current bus inputs
  function automatic bit modelHit(logic [31:0] pa, logic [1:0] kind, logic [1:0] psz,
                                  bit useData, logic [31:0] pd, logic [31:0] pm);
    int drop, nBytes, off, sh;
    longint unsigned wm, lane;
    if (!busValid) return 0;
    if (busFetch ? !kind[0] : !kind[1]) return 0;
    if (busSize == 2'd3) return 0;
    if (psz != 2'd3 && psz != busSize) return 0;
    drop = int'(busSize);
    if ((pa >> drop) != (busAddr >> drop)) return 0;
    if (useData && !busFetch) begin
      nBytes = 1 << drop;
      off = int'(busAddr[1:0]) & ~(nBytes - 1);
      sh = 8 * (4 - nBytes - off);
      wm = (64'd1 << (8 * nBytes)) - 1;
      lane = (longint'(busData) >> sh) & wm;
      if (((lane ^ longint'(pd)) & ~longint'(pm) & wm) != 0) return 0;
    end
    return 1;
  endfunction

  task automatic step(string tag);
    logic [1:0] expv;
    if (rst) expv = 2'b00;
    else begin
      expv[0] = modelHit(ch0Addr, ch0Kind, ch0Size, 0, 32'h0, 32'h0);
      expv[1] = modelHit(ch1Addr, ch1Kind, ch1Size, ch1DataEn, ch1Data, ch1Mask);
    end
    @(posedge clk);
    #1;
    nChecks++;
    if (brkPulse !== expv) begin
      nFails++;
      $display("FAIL %s: brkPulse actual=%b expected=%b (addr=%h size=%0d fetch=%b data=%h)",
               tag, brkPulse, expv, busAddr, busSize, busFetch, busData);
    end
  endtask

  task automatic bus(bit v, bit f, logic [1:0] sz, logic [31:0] a, logic [31:0] d);
    busValid = v; busFetch = f; busSize = sz; busAddr = a; busData = d;
  endtask

  initial begin
    rst = 1; bus(1, 0, 2'd2, 32'h1000, 32'h0);
    ch0Addr = 32'h1003; ch0Kind = 2'b11; ch0Size = 2'd3;
    ch1Addr = 32'h2000; ch1Kind = 2'b11; ch1Size = 2'd3;
    ch1DataEn = 0; ch1Data = 32'h0; ch1Mask = 32'h0;
    step("R10 reset"); step("R10 reset");
    rst = 0;

    // R3: one address, three widths
    bus(1, 0, 2'd2, 32'h1000, 0); step("R3 long");
    bus(1, 0, 2'd1, 32'h1002, 0); step("R3 word");
    bus(1, 0, 2'd0, 32'h1003, 0); step("R3 byte");
    // R1 / R2 boundaries
    bus(1, 0, 2'd2, 32'h1003, 0); step("R1 long low bits ignored");
    bus(1, 0, 2'd2, 32'h1004, 0); step("R1 long miss");
    bus(1, 0, 2'd1, 32'h1000, 0); step("R2 word miss");
    bus(1, 0, 2'd0, 32'h1002, 0); step("R2 byte miss");
    bus(1, 0, 2'd3, 32'h1003, 0); step("R2 illegal size");
    // R10: valid low, back-to-back
    bus(0, 0, 2'd0, 32'h1003, 0); step("R10 idle");
    bus(1, 0, 2'd0, 32'h1003, 0); step("R10 hit");
    step("R10 repeat hit");
    // R4 kind selector
    ch0Kind = 2'b01; bus(1, 0, 2'd0, 32'h1003, 0); step("R4 fetch-only data cycle");
    bus(1, 1, 2'd0, 32'h1003, 0); step("R4 fetch-only fetch cycle");
    ch0Kind = 2'b10; step("R4 data-only fetch cycle");
    ch0Kind = 2'b00; bus(1, 0, 2'd0, 32'h1003, 0); step("R4 off");
    ch0Kind = 2'b11;
    // R5 size selector
    ch0Size = 2'd1; bus(1, 0, 2'd2, 32'h1000, 0); step("R5 size mismatch");
    bus(1, 0, 2'd1, 32'h1002, 0); step("R5 size match");
    ch0Size = 2'd3;

    // channel 1 data conditions
    ch1DataEn = 1; ch1Data = 32'hCAFE_1234; ch1Mask = 32'h0000_00FF;
    bus(1, 0, 2'd2, 32'h2000, 32'hCAFE_12AA); step("R6 long masked match");
    bus(1, 0, 2'd2, 32'h2000, 32'hCAFF_12AA); step("R6 long data miss");
    bus(1, 0, 2'd2, 32'h2004, 32'hCAFE_1234); step("R6 addr miss data hit");
    ch1Data = 32'hFFFF_BEEF; ch1Mask = 32'h1234_0000;
    bus(1, 0, 2'd1, 32'h2000, 32'hBEEF_0000); step("R7 word upper lane");
    bus(1, 0, 2'd1, 32'h2002, 32'h0000_BEEF); step("R7 word lower lane");
    bus(1, 0, 2'd1, 32'h2002, 32'hBEEF_0000); step("R7 word wrong lane");
    ch1Data = 32'h0000_5A5A; ch1Mask = 32'h0;
    for (int ln = 0; ln < 4; ln++) begin
      ch1Addr = 32'h2000 + ln;
      bus(1, 0, 2'd0, 32'h2000 + ln, 32'h5A << (8 * (3 - ln))); step("R8 byte lane hit");
      bus(1, 0, 2'd0, 32'h2000 + ln, 32'h5A << (8 * ln)); step("R8 byte lane other");
    end
    ch1Addr = 32'h2000;
    bus(1, 1, 2'd2, 32'h2000, 32'hDEAD_DEAD); step("R9 fetch ignores data");
    ch1DataEn = 0; bus(1, 0, 2'd2, 32'h2000, 32'hDEAD_DEAD); step("R6 data disabled");

    // random phase around the break addresses
    for (int i = 0; i < 3000; i++) begin
      ch0Kind = 2'($urandom); ch0Size = 2'($urandom);
      ch1Kind = 2'($urandom); ch1Size = 2'($urandom);
      ch1DataEn = 1'($urandom); ch1Mask = ($urandom % 2) ? 32'h0 : $urandom;
      ch1Data = {16'($urandom), {2{8'($urandom % 4)}}};
      bus(($urandom % 5) != 0, 1'($urandom), 2'($urandom % 3),
          (($urandom % 2) ? 32'h1000 : 32'h2000) | ($urandom % 8),
          ($urandom % 2) ? {2{ch1Data[15:0]}} : $urandom);
      if ((i % 500) == 499) rst = 1;
      step("R5 random");
      rst = 0;
    end
    doneFlag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!doneFlag) begin
      nFails++;
      $display("FAIL R10 watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule